// File: doc/BRIEF.md
# Locked Access Boundary Gate

This block stands between a core's atomic read-modify-write requests and the shared memory interconnect. Each locked request brings a byte address and a byte count. The gate works out whether the access stays inside one 64-byte line or runs past a line boundary. An access that stays inside one line gets a cheap lock local to the core. An access that crosses a boundary needs a global bus lock. The global lock is granted only after every other bus master has acknowledged a stall request, and the stall stays in force until the read-modify-write has finished.

A detection mode can change how boundary-crossing accesses are handled. With detection off, they take the bus-lock path silently. In warn mode they raise an alignment-check fault and an event, then continue by the bus lock. In fatal mode they raise the fault, flag it as fatal and are not performed. Rate-limited mode behaves like warn mode, but it reports at most a programmable number of events in each window. The window length is a cycle count, and events over the limit go to a saturating drop counter.

A read-only capability byte tells software whether detection exists. When detection is absent, the detection enable does nothing.

Top module: `atomic_lock_gate`

## Requirements
- R1: An access is split when the line index (address bits 6 and up) of its first byte differs from that of its last byte (address + size - 1). A zero-byte access is never split.
- R2: An accepted non-split access raises lineLock and grant in the cycle after acceptance, never raises stallReq or busLock, and drops lineLock at the clock edge that samples rmwDone high.
- R3: A split access that goes by the bus path raises stallReq to every other master in the cycle after acceptance. busLock and grant rise only in the cycle after all stallAck bits are seen high.
- R4: busLock and stallReq stay high for exactly one cycle after the edge that samples rmwDone, then both fall.
- R5: In warn mode (cfgMode 1), a split access pulses respFault and reports an event (evtValid with evtAddr) in the cycle after acceptance, then proceeds by the bus path.
- R6: In fatal mode (cfgMode 2), a split access pulses respFault and respFatal together with an event in the cycle after acceptance. It raises no stallReq, busLock or grant, and reqReady stays high.
- R7: In rate-limited mode (cfgMode 3), at most cfgRateLimit events are reported per window of cfgWindowCycles cycles. The window counter starts at reset. A suppressed event increments dropCount and does not pulse evtValid, although respFault still pulses.
- R8: dropCount saturates at its all-ones value.
- R9: capReg bit 4 shows whether detection is built in. Without it, cfgDetectEn has no effect, and every split access takes the silent bus path. With it, cfgDetectEn low also gives the silent bus path (cfgMode 0 likewise).
- R10: Only sizes 0, 1, 2, 4, 8 and 16 are legal. Any other size pulses respIllegal in the cycle after acceptance and takes no lock of any kind.
- R11: A request is accepted only while reqReady is high, which is exactly when no lock is in progress. After reset, reqReady is high, all locks, stalls and response pulses are low, and dropCount is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Locked request present |
| reqReady | output | 1 | Gate idle, request accepted this cycle |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqSize | input | 5 | Byte count of the access |
| cfgDetectEn | input | 1 | Detection enable |
| cfgMode | input | 2 | 0 off, 1 warn, 2 fatal, 3 rate-limited warn |
| cfgRateLimit | input | CNT_W | Event limit per window |
| cfgWindowCycles | input | WIN_W | Window length in cycles |
| capReg | output | 8 | Capability byte, bit 4 = detection present |
| stallReq | output | N_OTHERS | Stall request to each other master |
| stallAck | input | N_OTHERS | Stall acknowledge from each other master |
| lineLock | output | 1 | Line-local lock held |
| busLock | output | 1 | Global bus lock held |
| grant | output | 1 | Requester may run the read-modify-write |
| rmwDone | input | 1 | Final write of the read-modify-write acknowledged |
| respFault | output | 1 | Alignment-check fault pulse |
| respFatal | output | 1 | Fatal fault pulse |
| respIllegal | output | 1 | Illegal size pulse |
| evtValid | output | 1 | Split-lock event report pulse |
| evtAddr | output | ADDR_W | Address of the reported access |
| dropCount | output | CNT_W | Saturating count of suppressed events |

## Verification
The bench uses addresses placed right at a line edge, where the last byte either just fits or just spills over. A classifier that is off by one would put these accesses on the wrong lock. Acknowledge delays from zero to several cycles show whether busLock waits for every master, because a gate that grants early would stall nothing. The bench also pins down the release cycle after rmwDone, where a gate that drops the lock one cycle early or late would be caught. In the fatal and rate-limited cases it checks that a blocked access never stalls the bus, that suppressed events still fault, and that reporting starts again once a window ends. A second instance built without the capability confirms that the enable is ignored there, and a long run of suppressed events shows whether dropCount sticks at its ceiling or wraps.

// File: rtl/atomic_lock_pkg.sv
package atomic_lock_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_WARN  = 2'd1,
    MODE_FATAL = 2'd2,
    MODE_RATE  = 2'd3
  } lockMode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LINE,
    ST_STALL,
    ST_BUS,
    ST_REL
  } lockState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic fault;
    logic fatal;
    logic illegal;
    logic evtTry;
  } ctlStrobe_t;

  localparam int CAP_BIT = 4;

endpackage

// File: rtl/atomic_lock_classifier.sv
module atomic_lock_classifier #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [4:0]        size,
  output logic              isSplit,
  output logic              isIllegal
);
  localparam int LINE_SHIFT = $clog2(LINE_BYTES);

  logic [ADDR_W-1:0] lastByte;

  always_comb begin
    lastByte = addr + ADDR_W'(size) - ADDR_W'(1);
    if (size == 5'd0) isSplit = 1'b0;
    else isSplit = (addr[ADDR_W-1:LINE_SHIFT] != lastByte[ADDR_W-1:LINE_SHIFT]);
    unique case (size)
      5'd0, 5'd1, 5'd2, 5'd4, 5'd8, 5'd16: isIllegal = 1'b0;
      default:                             isIllegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/atomic_lock_rate_limiter.sv
module atomic_lock_rate_limiter #(
  parameter int CNT_W = 8,
  parameter int WIN_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtTry,
  input  logic             rateMode,
  input  logic [CNT_W-1:0] limit,
  input  logic [WIN_W-1:0] windowCycles,
  output logic             allow,
  output logic [CNT_W-1:0] dropCount
);
  logic [WIN_W-1:0] winCnt;
  logic [CNT_W-1:0] evtCnt;
  logic [CNT_W-1:0] curCnt;
  logic             winEnd;

  always_comb begin
    winEnd = (windowCycles == '0) || (winCnt >= windowCycles - WIN_W'(1));
    curCnt = winEnd ? '0 : evtCnt;
    allow  = !rateMode || (curCnt < limit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt    <= '0;
      evtCnt    <= '0;
      dropCount <= '0;
    end else begin
      winCnt <= winEnd ? '0 : winCnt + WIN_W'(1);
      if (evtTry && allow && curCnt != '1) evtCnt <= curCnt + CNT_W'(1);
      else evtCnt <= curCnt;
      if (evtTry && !allow && dropCount != '1) dropCount <= dropCount + CNT_W'(1);
    end
  end
endmodule

// File: rtl/atomic_lock_datapath.sv
module atomic_lock_datapath
  import atomic_lock_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int CNT_W      = 8,
  parameter int WIN_W      = 32,
  parameter bit CAP_DETECT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [4:0]        reqSize,
  input  logic              cfgDetectEn,
  input  logic [1:0]        cfgMode,
  input  logic [CNT_W-1:0]  cfgRateLimit,
  input  logic [WIN_W-1:0]  cfgWindowCycles,
  input  ctlStrobe_t        strobe,
  output logic              isSplit,
  output logic              isIllegal,
  output lockMode_t         effMode,
  output logic [7:0]        capReg,
  output logic              respFault,
  output logic              respFatal,
  output logic              respIllegal,
  output logic              evtValid,
  output logic [ADDR_W-1:0] evtAddr,
  output logic [CNT_W-1:0]  dropCount
);
  logic allow;

  atomic_lock_classifier #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_class (
    .addr(reqAddr), .size(reqSize), .isSplit(isSplit), .isIllegal(isIllegal)
  );

  // detection only takes effect when the capability exists
  generate
    if (CAP_DETECT) begin : g_cap
      assign effMode = cfgDetectEn ? lockMode_t'(cfgMode) : MODE_OFF;
    end else begin : g_nocap
      assign effMode = MODE_OFF;
    end
  endgenerate

  always_comb begin
    capReg          = '0;
    capReg[CAP_BIT] = CAP_DETECT;
  end

  atomic_lock_rate_limiter #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_rate (
    .clk(clk), .rstN(rstN), .evtTry(strobe.evtTry), .rateMode(effMode == MODE_RATE),
    .limit(cfgRateLimit), .windowCycles(cfgWindowCycles),
    .allow(allow), .dropCount(dropCount)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respFault   <= 1'b0;
      respFatal   <= 1'b0;
      respIllegal <= 1'b0;
      evtValid    <= 1'b0;
      evtAddr     <= '0;
    end else begin
      respFault   <= strobe.fault;
      respFatal   <= strobe.fatal;
      respIllegal <= strobe.illegal;
      evtValid    <= strobe.evtTry && allow;
      if (strobe.capture) evtAddr <= reqAddr;
    end
  end
endmodule

// File: rtl/atomic_lock_ctrl.sv
module atomic_lock_ctrl
  import atomic_lock_pkg::*;
#(
  parameter int N_OTHERS = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                isSplit,
  input  logic                isIllegal,
  input  lockMode_t           effMode,
  input  logic [N_OTHERS-1:0] stallAck,
  input  logic                rmwDone,
  output logic                reqReady,
  output logic [N_OTHERS-1:0] stallReq,
  output logic                lineLock,
  output logic                busLock,
  output logic                grant,
  output ctlStrobe_t          strobe
);
  lockState_t state, stateNext;
  logic accept, splitGo;

  always_comb begin
    accept  = reqValid && (state == ST_IDLE);
    splitGo = accept && !isIllegal && isSplit;
    strobe.capture = accept;
    strobe.illegal = accept && isIllegal;
    strobe.fault   = splitGo && (effMode != MODE_OFF);
    strobe.fatal   = splitGo && (effMode == MODE_FATAL);
    strobe.evtTry  = strobe.fault;

    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept && !isIllegal) begin
        if (!isSplit)                     stateNext = ST_LINE;
        else if (effMode != MODE_FATAL)   stateNext = ST_STALL;
      end
      ST_LINE:  if (rmwDone)   stateNext = ST_IDLE;
      ST_STALL: if (&stallAck) stateNext = ST_BUS;
      ST_BUS:   if (rmwDone)   stateNext = ST_REL;
      ST_REL:                  stateNext = ST_IDLE;
      default:                 stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    reqReady = (state == ST_IDLE);
    lineLock = (state == ST_LINE);
    busLock  = (state == ST_BUS) || (state == ST_REL);
    grant    = (state == ST_LINE) || (state == ST_BUS);
    stallReq = (state == ST_STALL || busLock) ? '1 : '0;
  end
endmodule

// File: rtl/atomic_lock_gate.sv
module atomic_lock_gate
  import atomic_lock_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int N_OTHERS   = 3,
  parameter int CNT_W      = 8,
  parameter int WIN_W      = 32,
  parameter bit CAP_DETECT = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [4:0]          reqSize,
  input  logic                cfgDetectEn,
  input  logic [1:0]          cfgMode,
  input  logic [CNT_W-1:0]    cfgRateLimit,
  input  logic [WIN_W-1:0]    cfgWindowCycles,
  output logic [7:0]          capReg,
  output logic [N_OTHERS-1:0] stallReq,
  input  logic [N_OTHERS-1:0] stallAck,
  output logic                lineLock,
  output logic                busLock,
  output logic                grant,
  input  logic                rmwDone,
  output logic                respFault,
  output logic                respFatal,
  output logic                respIllegal,
  output logic                evtValid,
  output logic [ADDR_W-1:0]   evtAddr,
  output logic [CNT_W-1:0]    dropCount
);
  ctlStrobe_t strobe;
  lockMode_t  effMode;
  logic       isSplit, isIllegal;

  atomic_lock_ctrl #(.N_OTHERS(N_OTHERS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .isSplit(isSplit), .isIllegal(isIllegal),
    .effMode(effMode), .stallAck(stallAck), .rmwDone(rmwDone), .reqReady(reqReady),
    .stallReq(stallReq), .lineLock(lineLock), .busLock(busLock), .grant(grant),
    .strobe(strobe)
  );

  atomic_lock_datapath #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .CNT_W(CNT_W), .WIN_W(WIN_W),
    .CAP_DETECT(CAP_DETECT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqSize(reqSize),
    .cfgDetectEn(cfgDetectEn), .cfgMode(cfgMode), .cfgRateLimit(cfgRateLimit),
    .cfgWindowCycles(cfgWindowCycles), .strobe(strobe), .isSplit(isSplit),
    .isIllegal(isIllegal), .effMode(effMode), .capReg(capReg), .respFault(respFault),
    .respFatal(respFatal), .respIllegal(respIllegal), .evtValid(evtValid),
    .evtAddr(evtAddr), .dropCount(dropCount)
  );
endmodule

// File: rtl/atomic_lock_chk.sv
module atomic_lock_chk #(
  parameter int N_OTHERS = 3,
  parameter int CNT_W    = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [N_OTHERS-1:0] stallReq,
  input logic [N_OTHERS-1:0] stallAck,
  input logic                lineLock,
  input logic                busLock,
  input logic                grant,
  input logic                rmwDone,
  input logic                respFault,
  input logic                respFatal,
  input logic                reqReady,
  input logic [CNT_W-1:0]    dropCount
);
  // R2 / R3: never both locks, grant only under a lock
  a_r2_single_lock: assert property (@(posedge clk) disable iff (!rstN)
    !(busLock && lineLock));
  a_r2_grant_locked: assert property (@(posedge clk) disable iff (!rstN)
    grant |-> (busLock || lineLock));
  a_r2_line_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    lineLock |-> (stallReq == '0));
  // R3: bus lock follows full acknowledgement, stall held under it
  a_r3_ack_before_lock: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busLock) |-> $past((&stallAck) && (&stallReq)));
  a_r3_stall_covers: assert property (@(posedge clk) disable iff (!rstN)
    busLock |-> (&stallReq));
  // R4: lock falls two edges after rmwDone sampled
  a_r4_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busLock) |-> $past(rmwDone, 2));
  // R6: fatal always comes with fault
  a_r6_fatal_faults: assert property (@(posedge clk) disable iff (!rstN)
    respFatal |-> respFault);
  // R8: drop counter sticks at ceiling
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (dropCount == '1) |=> (dropCount == '1));
  // R11: ready only when no lock held
  a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !(busLock || lineLock || (|stallReq)));
endmodule

bind atomic_lock_gate atomic_lock_chk #(.N_OTHERS(N_OTHERS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .stallReq(stallReq), .stallAck(stallAck), .lineLock(lineLock),
  .busLock(busLock), .grant(grant), .rmwDone(rmwDone), .respFault(respFault),
  .respFatal(respFatal), .reqReady(reqReady), .dropCount(dropCount)
);

// File: tb/atomic_lock_gate_tb.sv
module atomic_lock_gate_tb;
  localparam int AW = 32;
  localparam int NO = 3;
  localparam int CW = 8;
  localparam int WW = 32;

  localparam int K_LINE = 0, K_BUS = 1, K_FATAL = 2, K_ILL = 3;

  typedef struct { int kind; bit fault; bit evt; } item_t;
  item_t expQ[$];

  logic clk = 0, rstN = 0;
  logic reqValid = 0, ncValid = 0;
  logic [AW-1:0] reqAddr = '0;
  logic [4:0] reqSize = '0;
  logic detEn = 0;
  logic [1:0] mode = 0;
  logic [CW-1:0] limit = '0;
  logic [WW-1:0] win = 32'd1000;
  logic [NO-1:0] ack = '0, ncAck = '0;
  logic done = 0, ncDone = 0;

  logic reqReady, lineLock, busLock, grant, respFault, respFatal, respIllegal, evtValid;
  logic [7:0] capReg;
  logic [NO-1:0] stallReq;
  logic [AW-1:0] evtAddr;
  logic [CW-1:0] dropCount;

  logic ncReady, ncLine, ncBus, ncGrant, ncFault, ncFatal, ncIll, ncEvt;
  logic [7:0] ncCap;
  logic [NO-1:0] ncStall;
  logic [AW-1:0] ncEvtAddr;
  logic [CW-1:0] ncDrop;

  int nVec = 0, nBad = 0;

  always #5 clk = ~clk;

  atomic_lock_gate #(.ADDR_W(AW), .N_OTHERS(NO), .CNT_W(CW), .WIN_W(WW)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqSize(reqSize), .cfgDetectEn(detEn), .cfgMode(mode), .cfgRateLimit(limit),
    .cfgWindowCycles(win), .capReg(capReg), .stallReq(stallReq), .stallAck(ack),
    .lineLock(lineLock), .busLock(busLock), .grant(grant), .rmwDone(done),
    .respFault(respFault), .respFatal(respFatal), .respIllegal(respIllegal),
    .evtValid(evtValid), .evtAddr(evtAddr), .dropCount(dropCount)
  );

  atomic_lock_gate #(.ADDR_W(AW), .N_OTHERS(NO), .CNT_W(CW), .WIN_W(WW), .CAP_DETECT(1'b0)) u_nocap (
    .clk(clk), .rstN(rstN), .reqValid(ncValid), .reqReady(ncReady), .reqAddr(reqAddr),
    .reqSize(reqSize), .cfgDetectEn(detEn), .cfgMode(mode), .cfgRateLimit(limit),
    .cfgWindowCycles(win), .capReg(ncCap), .stallReq(ncStall), .stallAck(ncAck),
    .lineLock(ncLine), .busLock(ncBus), .grant(ncGrant), .rmwDone(ncDone),
    .respFault(ncFault), .respFatal(ncFatal), .respIllegal(ncIll),
    .evtValid(ncEvt), .evtAddr(ncEvtAddr), .dropCount(ncDrop)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- monitor / scoreboard ----------------
  bit faultSeen = 0, evtSeen = 0, prevLine = 0, prevBus = 0;

  task automatic emit(input int kind, input bit f, input bit e);
    item_t x;
    if (expQ.size() == 0) begin
      check(0, "R11 unexpected outcome", kind, -1);
    end else begin
      x = expQ.pop_front();
      check(x.kind == kind, "R1/R10 outcome kind", kind, x.kind);
      check(x.fault == f, "R5/R9 fault flag", f, x.fault);
      check(x.evt == e, "R7 event flag", e, x.evt);
    end
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      faultSeen = 0; evtSeen = 0; prevLine = 0; prevBus = 0;
    end else begin
      faultSeen = faultSeen | respFault;
      evtSeen   = evtSeen | evtValid;
      if (respIllegal) begin emit(K_ILL, faultSeen, evtSeen); faultSeen = 0; evtSeen = 0; end
      if (respFatal)   begin emit(K_FATAL, faultSeen, evtSeen); faultSeen = 0; evtSeen = 0; end
      if (lineLock && !prevLine) begin emit(K_LINE, faultSeen, evtSeen); faultSeen = 0; evtSeen = 0; end
      if (busLock && !prevBus)   begin emit(K_BUS, faultSeen, evtSeen); faultSeen = 0; evtSeen = 0; end
      prevLine = lineLock;
      prevBus  = busLock;
    end
  end

  // ---------------- driver ----------------
  task automatic push(input int kind, input bit f, input bit e);
    item_t x;
    x.kind = kind; x.fault = f; x.evt = e;
    expQ.push_back(x);
  endtask

  task automatic txn(input logic [AW-1:0] a, input logic [4:0] s, input int kind,
                     input bit f, input bit e, input int dly);
    @(negedge clk);
    reqAddr = a; reqSize = s; reqValid = 1;
    push(kind, f, e);
    @(negedge clk);
    reqValid = 0;
    if (e) check(evtAddr == a, "R5 event address", evtAddr, a);
    if (kind == K_LINE) begin
      check(lineLock && grant, "R2 line lock granted", {lineLock, grant}, 2'b11);
      check(!busLock && stallReq == '0, "R2 no stall on line lock", stallReq, 0);
      done = 1;
      @(negedge clk);
      done = 0;
      check(!lineLock && reqReady, "R2 line lock released", lineLock, 0);
    end else if (kind == K_BUS) begin
      check(stallReq == '1 && !reqReady, "R3 stall raised", stallReq, 3'b111);
      for (int i = 0; i < dly; i++) begin
        check(!busLock && !grant, "R3 no lock before ack", busLock, 0);
        ack = (i % 2 == 0) ? 3'b011 : 3'b101;
        @(negedge clk);
      end
      check(!busLock, "R3 no lock on partial ack", busLock, 0);
      ack = '1;
      @(negedge clk);
      check(busLock && grant, "R3 bus lock after ack", {busLock, grant}, 2'b11);
      done = 1;
      @(negedge clk);
      done = 0;
      check(busLock && stallReq == '1 && !grant, "R4 lock held one cycle", busLock, 1);
      @(negedge clk);
      check(!busLock && stallReq == '0 && reqReady, "R4 lock released", {busLock, stallReq}, 0);
      ack = '0;
    end else begin
      check(!busLock && !lineLock && stallReq == '0 && reqReady,
            (kind == K_FATAL) ? "R6 no lock after fatal" : "R10 no lock on illegal",
            {busLock, lineLock, stallReq}, 0);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R11 reset state
    check(reqReady === 1'b1, "R11 ready after reset", reqReady, 1);
    check(busLock === 0 && lineLock === 0 && stallReq === '0, "R11 no lock after reset", {busLock, lineLock}, 0);
    check(respFault === 0 && evtValid === 0 && dropCount === '0, "R11 clean outputs", dropCount, 0);
    check(capReg == 8'h10, "R9 capability present", capReg, 8'h10);
    check(ncCap == 8'h00, "R9 capability absent", ncCap, 0);

    // R1/R2/R3/R4 off mode
    mode = 2'd0; detEn = 0;
    txn(32'h100, 5'd4,  K_LINE, 0, 0, 0);
    txn(32'h13C, 5'd4,  K_LINE, 0, 0, 0);   // R1 last byte 0x13F
    txn(32'h13E, 5'd4,  K_BUS,  0, 0, 0);   // R1 crosses 0x140
    txn(32'h1FF, 5'd2,  K_BUS,  0, 0, 2);
    txn(32'h140, 5'd16, K_LINE, 0, 0, 0);
    txn(32'h17F, 5'd0,  K_LINE, 0, 0, 0);   // R1 zero size
    txn(32'h138, 5'd8,  K_LINE, 0, 0, 0);
    txn(32'h139, 5'd8,  K_BUS,  0, 0, 3);
    txn(32'hFFFF_FFF8, 5'd16, K_BUS, 0, 0, 1);
    // R10 illegal sizes
    txn(32'h200, 5'd3,  K_ILL, 0, 0, 0);
    txn(32'h23F, 5'd7,  K_ILL, 0, 0, 0);
    txn(32'h200, 5'd31, K_ILL, 0, 0, 0);
    // R5 warn
    detEn = 1; mode = 2'd1;
    txn(32'h33D, 5'd4, K_BUS,  1, 1, 1);
    txn(32'h300, 5'd8, K_LINE, 0, 0, 0);
    // R6 fatal
    mode = 2'd2;
    txn(32'h47F, 5'd2, K_FATAL, 1, 1, 0);
    txn(32'h440, 5'd4, K_LINE, 0, 0, 0);
    // R9 enable low makes detection silent
    detEn = 0;
    txn(32'h47F, 5'd2, K_BUS, 0, 0, 0);
    // R9 no capability: enable ignored
    detEn = 1; mode = 2'd2;
    @(negedge clk);
    reqAddr = 32'h57E; reqSize = 5'd4; ncValid = 1;
    @(negedge clk);
    ncValid = 0;
    check(ncFault == 0 && ncFatal == 0 && ncEvt == 0, "R9 no fault without capability", ncFault, 0);
    check(ncStall == '1, "R9 split takes bus path without capability", ncStall, 3'b111);
    ncAck = '1;
    @(negedge clk);
    check(ncBus == 1, "R9 bus lock without capability", ncBus, 1);
    ncDone = 1; @(negedge clk); ncDone = 0; @(negedge clk); ncAck = '0;
    check(ncBus == 0 && ncReady, "R9 released", ncBus, 0);

    // R7 rate limit
    doReset();
    mode = 2'd3; detEn = 1; limit = 8'd2; win = 32'd2000;
    txn(32'h63E, 5'd4, K_BUS, 1, 1, 0);
    txn(32'h63E, 5'd4, K_BUS, 1, 1, 1);
    txn(32'h63E, 5'd4, K_BUS, 1, 0, 0);
    txn(32'h63E, 5'd4, K_BUS, 1, 0, 2);
    check(dropCount == 8'd2, "R7 dropped events counted", dropCount, 2);
    repeat (2100) @(negedge clk);
    txn(32'h67F, 5'd8, K_BUS, 1, 1, 0);     // R7 new window reports again
    check(dropCount == 8'd2, "R7 drop count unchanged after report", dropCount, 2);
    // R8 saturation
    limit = 8'd0;
    for (int i = 0; i < 260; i++) txn(32'h6FF, 5'd2, K_BUS, 1, 0, 0);
    check(dropCount == 8'hFF, "R8 drop count saturates", dropCount, 8'hFF);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R11 all outcomes observed", expQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule